// File: doc/BRIEF.md
# Multiplexed-Channel Hit Finder

This block is the first digital stage behind a wire-chamber digitizer. A single converter interleaves many wire channels into one stream of 10-bit samples. Each sample arrives with its channel number and a valid strobe. The block time-shares one datapath across all channels and keeps a separate history for each channel in a small register store indexed by channel number.

Each accepted sample goes through a three-tap median, which removes single-sample spikes. A leading-edge test then compares the median output with the median output from a configurable number of samples earlier. Because that distance is configurable, slow and fast rises both cross the same threshold.

The output stream is a per-channel delayed copy of the filtered data. It carries a marker for samples that are themselves edges and a keep flag that opens a window of configurable length before and after each edge. The keep flag drives zero suppression downstream. A registered trigger reports whether any channel's latest sample was an edge. It is intended for local self-triggering.

Top module: `hit_finder_mux`

## Requirements
- R1: A sample is taken only in a cycle with `in_valid` high. Exactly one cycle after each taken sample, `out_valid` is high and `out_chan` equals that sample's channel. In every other cycle `out_valid` is low.
- R2: Each channel's history is independent of the other channels. Reset clears all raw and filtered history to zero, clears all edge history and the trigger, and holds `out_valid` low.
- R3: The filtered value of a sample is the median of that raw sample and the two raw samples before it on the same channel.
- R4: `out_data` is the filtered value of the same channel's sample taken PRE_MAX samples earlier (4 by default). The value is zero when that sample lies before reset.
- R5: A sample is an edge when its filtered value exceeds the filtered value from L samples earlier on its channel, and the difference is strictly greater than `cfg_thresh`.
- R6: `cfg_lag` sets L. A value of 0 acts as 1, and values above MAX_LAG act as MAX_LAG.
- R7: `out_hit` is high exactly when the delayed sample shown on `out_data` was an edge. It is low whenever `out_valid` is low.
- R8: `out_keep` is high when an edge lies on the same channel within `cfg_pre` samples after the delayed sample, within `cfg_post` samples before it, or at the sample itself. A `cfg_pre` value above PRE_MAX acts as PRE_MAX.
- R9: Each channel has a flag that holds whether its most recent sample was an edge. `trig` is the OR of all channel flags, registered one cycle after the sample that updates a flag.
- R10: Cycles without `in_valid` change no channel state, so `trig` holds its value across idle stretches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_chan | input | $clog2(NUM_CH) | Channel number of the sample |
| in_sample | input | DATA_W | Raw sample |
| cfg_thresh | input | DATA_W | Edge threshold in counts |
| cfg_lag | input | $clog2(MAX_LAG+1) | Rise distance in samples |
| cfg_pre | input | $clog2(PRE_MAX+1) | Kept samples ahead of an edge |
| cfg_post | input | POST_W | Kept samples after an edge |
| out_valid | output | 1 | Output sample strobe |
| out_chan | output | $clog2(NUM_CH) | Channel of the output sample |
| out_data | output | DATA_W | Delayed filtered sample |
| out_hit | output | 1 | Delayed sample is an edge |
| out_keep | output | 1 | Delayed sample lies in a keep window |
| trig | output | 1 | Registered self-trigger |

## Verification
The bench builds the block with NUM_CH=4 and otherwise default parameters: 10-bit data, MAX_LAG=4, PRE_MAX=4 and a 4-bit post count. Four channels keep each run short, yet the channel store, the per-channel delay and the trigger OR are still interleaved. The bench sweeps every lag setting, including the clamped values 0 and 7. It crosses them with pre-window settings 0, 2, 4 and a clamped 6, and post settings 0 and 3. Each combination runs on waveforms with channel-specific rise slopes, lone spikes and idle gaps, with both forward and reversed channel order. Expected outputs come from per-channel sample lists in the bench, using index arithmetic over whole windows.

// File: rtl/hf_pkg.sv
package hf_pkg;
   // saturate an integer setting into [lo, hi]
   function automatic int clamp_int(input int v, input int lo, input int hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction
endpackage

// File: rtl/hf_median3.sv
module hf_median3 #(
   parameter int W = 10
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] c,
   output logic [W-1:0] m
);
   logic [W-1:0] lo_ab, hi_ab, lo_hc;
   always_comb begin
      lo_ab = (a < b) ? a : b;
      hi_ab = (a < b) ? b : a;
      lo_hc = (hi_ab < c) ? hi_ab : c;
      m     = (lo_ab > lo_hc) ? lo_ab : lo_hc;
   end
endmodule

// File: rtl/hf_edge_test.sv
module hf_edge_test #(
   parameter int W       = 10,
   parameter int HIST    = 4,
   parameter int MAX_LAG = 4
) (
   input  logic [W-1:0]           cur,
   input  logic [HIST-1:0][W-1:0] hist,
   input  logic [$clog2(MAX_LAG+1)-1:0] lag,
   input  logic [W-1:0]           thresh,
   output logic                   edge_o
);
   import hf_pkg::*;
   int           lag_c;
   logic [W-1:0] ref_v;
   logic [W:0]   diff;

   always_comb begin
      lag_c = clamp_int(int'(lag), 1, MAX_LAG);
      ref_v = '0;
      for (int k = 0; k < MAX_LAG; k++)
         if (k + 1 == lag_c) ref_v = hist[k];
      diff   = {1'b0, cur} - {1'b0, ref_v};
      edge_o = !diff[W] && (diff[W-1:0] > thresh);
   end
endmodule

// File: rtl/hf_chan_mem.sv
module hf_chan_mem #(
   parameter int NUM_CH  = 16,
   parameter int DATA_W  = 10,
   parameter int HIST    = 4,
   parameter int PRE_MAX = 4,
   parameter int POST_W  = 4,
   localparam int CH_W   = $clog2(NUM_CH)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic [CH_W-1:0]             ch,
   input  logic [DATA_W-1:0]           wr_raw,
   input  logic [DATA_W-1:0]           wr_filt,
   input  logic                        wr_edge,
   input  logic [POST_W-1:0]           wr_cnt,
   output logic [DATA_W-1:0]           rd_raw1,
   output logic [DATA_W-1:0]           rd_raw2,
   output logic [HIST-1:0][DATA_W-1:0] rd_filt,
   output logic [PRE_MAX-1:0]          rd_edge,
   output logic [POST_W-1:0]           rd_cnt
);
   logic [DATA_W-1:0]           raw1_q [NUM_CH];
   logic [DATA_W-1:0]           raw2_q [NUM_CH];
   logic [HIST-1:0][DATA_W-1:0] filt_q [NUM_CH];
   logic [PRE_MAX-1:0]          edge_q [NUM_CH];
   logic [POST_W-1:0]           cnt_q  [NUM_CH];

   assign rd_raw1 = raw1_q[ch];
   assign rd_raw2 = raw2_q[ch];
   assign rd_filt = filt_q[ch];
   assign rd_edge = edge_q[ch];
   assign rd_cnt  = cnt_q[ch];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_CH; i++) begin
            raw1_q[i] <= '0;
            raw2_q[i] <= '0;
            filt_q[i] <= '0;
            edge_q[i] <= '0;
            cnt_q[i]  <= '0;
         end
      end else if (we) begin
         raw2_q[ch] <= raw1_q[ch];
         raw1_q[ch] <= wr_raw;
         filt_q[ch][0] <= wr_filt;
         for (int k = 1; k < HIST; k++)
            filt_q[ch][k] <= filt_q[ch][k-1];
         edge_q[ch][0] <= wr_edge;
         for (int k = 1; k < PRE_MAX; k++)
            edge_q[ch][k] <= edge_q[ch][k-1];
         cnt_q[ch] <= wr_cnt;
      end
   end
endmodule

// File: rtl/hit_finder_mux.sv
module hit_finder_mux #(
   parameter int NUM_CH  = 16,
   parameter int DATA_W  = 10,
   parameter int MAX_LAG = 4,
   parameter int PRE_MAX = 4,
   parameter int POST_W  = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   input  logic [$clog2(NUM_CH)-1:0]    in_chan,
   input  logic [DATA_W-1:0]            in_sample,
   input  logic [DATA_W-1:0]            cfg_thresh,
   input  logic [$clog2(MAX_LAG+1)-1:0] cfg_lag,
   input  logic [$clog2(PRE_MAX+1)-1:0] cfg_pre,
   input  logic [POST_W-1:0]            cfg_post,
   output logic                         out_valid,
   output logic [$clog2(NUM_CH)-1:0]    out_chan,
   output logic [DATA_W-1:0]            out_data,
   output logic                         out_hit,
   output logic                         out_keep,
   output logic                         trig
);
   import hf_pkg::*;
   localparam int CH_W = $clog2(NUM_CH);
   localparam int HIST = (MAX_LAG > PRE_MAX) ? MAX_LAG : PRE_MAX;

   initial begin
      assert (NUM_CH >= 2 && (1 << CH_W) == NUM_CH)
         else $error("NUM_CH must be a power of two, at least 2");
      assert (DATA_W >= 4) else $error("DATA_W too small");
      assert (MAX_LAG >= 1 && PRE_MAX >= 1 && POST_W >= 1)
         else $error("window parameters must be positive");
   end

   logic [DATA_W-1:0]           raw1, raw2, med;
   logic [HIST-1:0][DATA_W-1:0] fhist;
   logic [PRE_MAX-1:0]          ehist;
   logic [POST_W-1:0]           post_cnt, post_next;
   logic                        edge_now, edge_old;
   logic [PRE_MAX-1:0]          win, pre_term;
   logic                        keep_now;
   logic [NUM_CH-1:0]           ch_flag;
   int                          pre_c;

   hf_median3 #(.W(DATA_W)) u_med (
      .a(in_sample), .b(raw1), .c(raw2), .m(med)
   );

   hf_edge_test #(.W(DATA_W), .HIST(HIST), .MAX_LAG(MAX_LAG)) u_edge (
      .cur(med), .hist(fhist), .lag(cfg_lag), .thresh(cfg_thresh),
      .edge_o(edge_now)
   );

   hf_chan_mem #(
      .NUM_CH(NUM_CH), .DATA_W(DATA_W), .HIST(HIST),
      .PRE_MAX(PRE_MAX), .POST_W(POST_W)
   ) u_mem (
      .clk(clk), .rst_n(rst_n), .we(in_valid), .ch(in_chan),
      .wr_raw(in_sample), .wr_filt(med), .wr_edge(edge_now),
      .wr_cnt(post_next),
      .rd_raw1(raw1), .rd_raw2(raw2), .rd_filt(fhist),
      .rd_edge(ehist), .rd_cnt(post_cnt)
   );

   // the delayed sample sits PRE_MAX samples back on this channel
   assign edge_old = ehist[PRE_MAX-1];
   assign pre_c    = clamp_int(int'(cfg_pre), 0, PRE_MAX);

   // win[j]: edge flag of the sample j steps back (0 = current)
   generate
      for (genvar j = 0; j < PRE_MAX; j++) begin : g_win
         if (j == 0) begin : g_now
            assign win[j] = edge_now;
         end else begin : g_hist
            assign win[j] = ehist[j-1];
         end
         assign pre_term[j] = win[j] && (j >= PRE_MAX - pre_c);
      end
   endgenerate

   always_comb begin
      if (edge_old)          post_next = cfg_post;
      else if (post_cnt != 0) post_next = post_cnt - 1'b1;
      else                    post_next = post_cnt;
      keep_now = edge_old || (|pre_term) || (post_cnt != 0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_chan  <= '0;
         out_data  <= '0;
         out_hit   <= 1'b0;
         out_keep  <= 1'b0;
         ch_flag   <= '0;
         trig      <= 1'b0;
      end else begin
         out_valid <= in_valid;
         trig      <= |ch_flag;
         if (in_valid) begin
            out_chan          <= in_chan;
            out_data          <= fhist[PRE_MAX-1];
            out_hit           <= edge_old;
            out_keep          <= keep_now;
            ch_flag[in_chan]  <= edge_now;
         end else begin
            out_hit  <= 1'b0;
            out_keep <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/hf_checker.sv
module hf_checker #(
   parameter int CH_W = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [CH_W-1:0] in_chan,
   input logic            out_valid,
   input logic [CH_W-1:0] out_chan,
   input logic            out_hit,
   input logic            out_keep,
   input logic            trig
);
   p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_no_spurious_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_chan_echo_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_chan == $past(in_chan));
   p_quiet_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !out_hit && !out_keep);
   p_hit_in_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_hit |-> out_keep);
   p_trig_holds_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !$past(in_valid)) |=> $stable(trig));
   p_trig_needs_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trig) |-> $past(in_valid, 2));
endmodule

bind hit_finder_mux hf_checker #(.CH_W($clog2(NUM_CH))) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
   .out_valid(out_valid), .out_chan(out_chan), .out_hit(out_hit),
   .out_keep(out_keep), .trig(trig)
);

// File: tb/hit_finder_mux_test.sv
module hit_finder_mux_test;
   localparam int NCH   = 4;
   localparam int DW    = 10;
   localparam int MLAG  = 4;
   localparam int PMAX  = 4;
   localparam int PW    = 4;
   localparam int NSAMP = 100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [1:0] in_chan = '0;
   logic [DW-1:0] in_sample = '0;
   logic [DW-1:0] cfg_thresh = '0;
   logic [2:0] cfg_lag = 3'd1;
   logic [2:0] cfg_pre = '0;
   logic [PW-1:0] cfg_post = '0;
   logic out_valid, out_hit, out_keep, trig;
   logic [1:0] out_chan;
   logic [DW-1:0] out_data;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   hit_finder_mux #(.NUM_CH(NCH), .DATA_W(DW), .MAX_LAG(MLAG),
                    .PRE_MAX(PMAX), .POST_W(PW)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
      .in_sample(in_sample), .cfg_thresh(cfg_thresh), .cfg_lag(cfg_lag),
      .cfg_pre(cfg_pre), .cfg_post(cfg_post), .out_valid(out_valid),
      .out_chan(out_chan), .out_data(out_data), .out_hit(out_hit),
      .out_keep(out_keep), .trig(trig)
   );

   // reference lists, indexed by channel and per-channel sample number
   int raw  [NCH][NSAMP];
   int filt [NCH][NSAMP];
   bit edg  [NCH][NSAMP];
   int cnt  [NCH];
   bit flag [NCH];
   int lag_e, pre_e, post_e, thr_e;

   bit e_valid; int e_chan, e_data; bit e_hit, e_keep, e_trig;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int med3(input int a, input int b, input int c);
      int lo, hi;
      lo = (a < b) ? a : b;
      hi = (a < b) ? b : a;
      if (c <= lo) return lo;
      if (c >= hi) return hi;
      return c;
   endfunction

   function automatic int wave(input int ch, input int n);
      int v, st;
      v  = 40 + ch * 9 + ((n * 7 + ch) % 3) - 1;
      st = 2 * (ch + 1);
      if (n >= 30 && n < 44) v += ((st * (n - 29)) > 48) ? 48 : st * (n - 29);
      if (n >= 70 && n < 80) v += ((st * (n - 69)) > 24) ? 24 : st * (n - 69);
      if (n == 15 + ch) v += 200;   // lone spike, removed by the median
      if (n == 55) v = 900;        // tall lone spike on every channel
      return v;
   endfunction

   task automatic model_push(input int ch, input int v);
      int n, r1, r2, m, rf, idx, lo, hi;
      n = cnt[ch];
      r1 = (n >= 1) ? raw[ch][n-1] : 0;
      r2 = (n >= 2) ? raw[ch][n-2] : 0;
      m  = med3(v, r1, r2);
      raw[ch][n] = v;
      filt[ch][n] = m;
      rf = (n >= lag_e) ? filt[ch][n-lag_e] : 0;
      edg[ch][n] = (m > rf) && ((m - rf) > thr_e);
      idx = n - PMAX;
      e_valid = 1'b1;
      e_chan  = ch;
      e_data  = (idx >= 0) ? filt[ch][idx] : 0;
      e_hit   = (idx >= 0) ? edg[ch][idx] : 1'b0;
      e_keep  = 1'b0;
      lo = idx - post_e; hi = idx + pre_e;
      if (lo < 0) lo = 0;
      for (int j = lo; j <= hi; j++) if (j <= n && edg[ch][j]) e_keep = 1'b1;
      flag[ch] = edg[ch][n];
      cnt[ch]  = n + 1;
   endtask

   task automatic step_check();
      chk("R1 out_valid", out_valid, e_valid);
      if (e_valid) begin
         chk("R1 out_chan", out_chan, e_chan);
         chk("R3 R4 out_data", out_data, e_data);
         chk("R5 R6 R7 out_hit", out_hit, e_hit);
         chk("R8 out_keep", out_keep, e_keep);
      end else begin
         chk("R7 R10 idle out_hit", out_hit, 0);
         chk("R8 R10 idle out_keep", out_keep, 0);
      end
      chk("R9 R10 trig", trig, e_trig);
      e_trig = flag[0] | flag[1] | flag[2] | flag[3];
   endtask

   task automatic run_cfg(input int lagv, input int prev, input int postv,
                          input bit rev);
      int k, rr;
      bit busy;
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0;
      cfg_lag = 3'(lagv); cfg_pre = 3'(prev); cfg_post = PW'(postv);
      lag_e = (lagv == 0) ? 1 : ((lagv > MLAG) ? MLAG : lagv);
      pre_e = (prev > PMAX) ? PMAX : prev;
      post_e = postv;
      thr_e = 6 + 2 * lag_e;
      cfg_thresh = DW'(thr_e);
      for (int c = 0; c < NCH; c++) begin cnt[c] = 0; flag[c] = 1'b0; end
      @(negedge clk); @(negedge clk);
      // R2: reset state
      chk("R2 reset out_valid", out_valid, 0);
      chk("R2 reset trig", trig, 0);
      rst_n = 1'b1;
      e_valid = 1'b0; e_trig = 1'b0;
      k = 0; rr = 0; busy = 1'b1;
      while (busy) begin
         @(negedge clk);
         step_check();
         e_valid = 1'b0;
         if (cnt[NCH-1] >= NSAMP && cnt[0] >= NSAMP) begin
            in_valid = 1'b0;
            busy = 1'b0;
         end else if ((k % 9) == 8 || (k % 23) == 11) begin
            in_valid = 1'b0;
         end else begin
            int ch;
            ch = rev ? (NCH - 1 - (rr % NCH)) : (rr % NCH);
            rr++;
            in_valid = 1'b1;
            in_chan = 2'(ch);
            in_sample = DW'(wave(ch, cnt[ch]));
            model_push(ch, wave(ch, cnt[ch]));
         end
         k++;
      end
      repeat (3) begin
         @(negedge clk);
         step_check();
         e_valid = 1'b0;
      end
   endtask

   initial begin
      int lags[6]  = '{0, 1, 2, 3, 4, 7};
      int pres[4]  = '{0, 2, 4, 6};
      int posts[2] = '{0, 3};
      for (int a = 0; a < 6; a++)
         for (int b = 0; b < 4; b++)
            for (int c = 0; c < 2; c++)
               run_cfg(lags[a], pres[b], posts[c], ((a + b + c) % 2) == 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog R1 actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule